// File: doc/BRIEF.md
# Debug Mode Entry Controller

This block sits beside a processor core's exception logic and decides, for every exception or interrupt event, whether the core branches to its normal interrupt vector or drops into debug mode. Event sources are a vector of internal event pulses plus two external debug-port request lines, one urgent and one ordinary. A per-source enable vector steers each source to debug entry or to the normal vector. One strap, sampled only while reset is held, decides whether debug mode may ever be used. A second strap lets the core come out of reset already in debug mode.

While the block is in debug mode, a fetch-redirect output tells the core to take every instruction from the serial debug port. A return-from-interrupt indication ends debug mode. A write-one-to-clear cause register shows which source caused the latest entry. It also collects any events that arrive while the core is already in debug mode.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: The allow strap is captured on every clock edge that sees rst_n low. When the captured value is 0, every event is sent to its normal vector whatever the enable bits say, and debug mode is never entered.
- R2: Changes on either strap after reset is released have no effect on allow, entry or mode.
- R3: If both the allow strap and the boot strap are high while reset is held, dbg_mode_o is 1 straight after reset. Otherwise dbg_mode_o is 0 after reset.
- R4: Source indices are: internal event k is index k, the ordinary external request is index NUM_EVT, and the urgent one is index NUM_EVT+1. Priority goes urgent first, then ordinary, then internal events with the lowest index first. Only the winning source is serviced in a cycle, and the other sources in that cycle are dropped.
- R5: If debug is allowed and the block is not in debug mode, a winner whose enable bit is 1 gives a one-cycle dbg_enter_o pulse on the next cycle. dbg_mode_o goes to 1 on that same cycle, and status_o is replaced with the one-hot bit of the winner.
- R6: A winner that does not enter debug gives a one-cycle vec_take_o pulse on the next cycle, with vec_idx_o equal to its index. When vec_take_o is 0, vec_idx_o is 0.
- R7: fetch_port_o is 1 exactly while dbg_mode_o is 1.
- R8: rfi_i high in debug mode clears dbg_mode_o on the next cycle. Outside debug mode, rfi_i has no effect.
- R9: Events that arrive in debug mode never cause entry or a vector pulse. Their bits are ORed into status_o.
- R10: A 1 in stat_clr_i clears that status bit. In the same cycle, a set or a cause load wins over a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the straps are sampled while it is low |
| allow_strap_i | input | 1 | Debug-allowed strap |
| boot_strap_i | input | 1 | Start-in-debug strap |
| evt_i | input | NUM_EVT | Internal exception/interrupt event pulses |
| ext_lo_i | input | 1 | Ordinary external debug request |
| ext_hi_i | input | 1 | Urgent external debug request |
| dbg_en_i | input | NUM_EVT+2 | Per-source debug-entry enable, indexed as in R4 |
| rfi_i | input | 1 | Return-from-interrupt executed |
| stat_clr_i | input | NUM_EVT+2 | Write-one-to-clear mask for status_o |
| dbg_mode_o | output | 1 | Core is in debug mode |
| fetch_port_o | output | 1 | Fetch instructions from the debug port |
| dbg_enter_o | output | 1 | One-cycle pulse on debug entry |
| vec_take_o | output | 1 | One-cycle pulse: take the normal vector |
| vec_idx_o | output | IDX_W | Index of the source taking its vector |
| status_o | output | NUM_EVT+2 | Entry cause and events seen in debug mode |

## Verification
Two functions can fall in the same cycle. One pair is a return-from-interrupt and a fresh event while in debug mode. The other is a status clear and a status set or cause load on the same bit. The bench drives both pairs in a single step. It expects the core to leave debug with the event only recorded and no vector pulse, and it expects the set or load to win over the clear. A scoreboard model of mode, pulses, index and status, written from the requirements, judges every cycle.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;
  typedef enum logic {
    MODE_RUN   = 1'b0,
    MODE_DEBUG = 1'b1
  } dbg_mode_e;
endpackage

// File: rtl/dbg_strap_latch.sv
// Holds the debug-allowed strap; it is reloaded only while reset is held.
module dbg_strap_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic allow_strap_i,
  output logic allow_o
);
  logic allow_q;

  always_ff @(posedge clk) begin
    if (!rst_n) allow_q <= allow_strap_i;
  end

  assign allow_o = allow_q;

  // R2: frozen once reset is released
  a_r2_allow_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(allow_q));
endmodule

// File: rtl/dbg_src_arbiter.sv
// Fixed priority: urgent request, ordinary request, then internal events
// with the lowest index first.
module dbg_src_arbiter #(
  parameter int NUM_EVT = 8,
  localparam int NSRC  = NUM_EVT + 2,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]  src_i,
  output logic             any_o,
  output logic [IDX_W-1:0] win_o
);
  function automatic logic [IDX_W-1:0] pick(input logic [NSRC-1:0] s);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NUM_EVT - 1; i >= 0; i--) begin
      if (s[i]) r = i[IDX_W-1:0];
    end
    if (s[NSRC-2]) r = IDX_W'(NSRC - 2);
    if (s[NSRC-1]) r = IDX_W'(NSRC - 1);
    return r;
  endfunction

  assign any_o = |src_i;
  assign win_o = pick(src_i);
endmodule

// File: rtl/dbg_cause_reg.sv
// Write-one-to-clear status; a load or set in the same cycle wins over a clear.
module dbg_cause_reg #(
  parameter int NSRC = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [NSRC-1:0] load_val_i,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] status_o
);
  logic [NSRC-1:0] stat_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      stat_q <= '0;
    else if (load_i) stat_q <= load_val_i;
    else             stat_q <= (stat_q & ~clr_i) | set_i;
  end

  assign status_o = stat_q;

  // R10: a clear with no set or load empties the bit
  a_r10_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && (clr_i & ~set_i) != '0) |=> ((status_o & $past(clr_i & ~set_i)) == '0));
  // R10: a set bit is present on the next cycle even if cleared
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && set_i != '0) |=> ((status_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl #(
  parameter int NUM_EVT = 8,
  localparam int NSRC   = NUM_EVT + 2,
  localparam int IDX_W  = $clog2(NSRC),
  localparam int HI_IDX = NSRC - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             allow_strap_i,
  input  logic             boot_strap_i,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic             ext_lo_i,
  input  logic             ext_hi_i,
  input  logic [NSRC-1:0]  dbg_en_i,
  input  logic             rfi_i,
  input  logic [NSRC-1:0]  stat_clr_i,
  output logic             dbg_mode_o,
  output logic             fetch_port_o,
  output logic             dbg_enter_o,
  output logic             vec_take_o,
  output logic [IDX_W-1:0] vec_idx_o,
  output logic [NSRC-1:0]  status_o
);
  import dbg_entry_pkg::*;

  function automatic logic [NSRC-1:0] idx_to_bit(input logic [IDX_W-1:0] k);
    logic [NSRC-1:0] b;
    b = '0;
    b[k] = 1'b1;
    return b;
  endfunction

  logic [NSRC-1:0]  src;
  logic             any_src;
  logic [IDX_W-1:0] win;
  logic             allow;
  logic             in_dbg;
  logic             enter_now;
  logic             vector_now;
  logic             leave_now;
  dbg_mode_e        mode_q;
  logic             enter_q, take_q;
  logic [IDX_W-1:0] idx_q;

  assign src = {ext_hi_i, ext_lo_i, evt_i};

  dbg_strap_latch u_strap (
    .clk(clk), .rst_n(rst_n), .allow_strap_i(allow_strap_i), .allow_o(allow)
  );

  dbg_src_arbiter #(.NUM_EVT(NUM_EVT)) u_arb (
    .src_i(src), .any_o(any_src), .win_o(win)
  );

  assign in_dbg     = (mode_q == MODE_DEBUG);
  assign enter_now  = !in_dbg && any_src && allow && dbg_en_i[win];
  assign vector_now = !in_dbg && any_src && !enter_now;
  assign leave_now  = in_dbg && rfi_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= (allow_strap_i && boot_strap_i) ? MODE_DEBUG : MODE_RUN;
      enter_q <= 1'b0;
      take_q  <= 1'b0;
      idx_q   <= '0;
    end else begin
      if (enter_now)      mode_q <= MODE_DEBUG;
      else if (leave_now) mode_q <= MODE_RUN;
      enter_q <= enter_now;
      take_q  <= vector_now;
      idx_q   <= vector_now ? win : '0;
    end
  end

  dbg_cause_reg #(.NSRC(NSRC)) u_cause (
    .clk(clk), .rst_n(rst_n),
    .load_i(enter_now), .load_val_i(idx_to_bit(win)),
    .set_i(in_dbg ? src : '0), .clr_i(stat_clr_i),
    .status_o(status_o)
  );

  assign dbg_mode_o   = in_dbg;
  assign fetch_port_o = in_dbg;
  assign dbg_enter_o  = enter_q;
  assign vec_take_o   = take_q;
  assign vec_idx_o    = idx_q;

  // R1: no entry when debug is not allowed
  a_r1_no_entry_disallowed: assert property (@(posedge clk) disable iff (!rst_n)
    !allow |=> !dbg_enter_o);
  // R4: the urgent request is always the one serviced
  a_r4_urgent_first: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbg_mode_o && ext_hi_i) |=>
      ((vec_take_o && vec_idx_o == IDX_W'(HI_IDX)) || (dbg_enter_o && status_o[HI_IDX])));
  // R5/R6: entry and vector pulses never coincide
  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(dbg_enter_o && vec_take_o));
  // R8: return-from-interrupt leaves debug mode
  a_r8_rfi_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_mode_o && rfi_i) |=> !dbg_mode_o);
  // R9: no re-entry and no vector while in debug mode
  a_r9_no_reentry: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_mode_o |=> (!dbg_enter_o && !vec_take_o));
  // R5: an entry pulse comes with debug mode on
  a_r5_enter_sets_mode: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dbg_enter_o) |-> dbg_mode_o);
endmodule

// File: tb/dbg_entry_ctrl_test.sv
module dbg_entry_ctrl_test;
  localparam int NE = 8;
  localparam int NS = NE + 2;
  localparam int IW = $clog2(NS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic allow_strap = 1'b0, boot_strap = 1'b0;
  logic [NE-1:0] evt = '0;
  logic ext_lo = 1'b0, ext_hi = 1'b0, rfi = 1'b0;
  logic [NS-1:0] en = '0, clr = '0;
  logic dbg_mode, fetch_port, dbg_enter, vec_take;
  logic [IW-1:0] vec_idx;
  logic [NS-1:0] status;

  always #4 clk = ~clk;  // 125 MHz

  dbg_entry_ctrl #(.NUM_EVT(NE)) uut (
    .clk(clk), .rst_n(rst_n), .allow_strap_i(allow_strap), .boot_strap_i(boot_strap),
    .evt_i(evt), .ext_lo_i(ext_lo), .ext_hi_i(ext_hi), .dbg_en_i(en), .rfi_i(rfi),
    .stat_clr_i(clr), .dbg_mode_o(dbg_mode), .fetch_port_o(fetch_port),
    .dbg_enter_o(dbg_enter), .vec_take_o(vec_take), .vec_idx_o(vec_idx), .status_o(status)
  );

  typedef struct {
    logic mode; logic enter; logic take; logic [IW-1:0] idx; logic [NS-1:0] stat;
    string tag;
  } exp_t;
  exp_t q[$];

  int errors = 0, checks = 0;
  bit done = 0;
  logic m_allow = 0, m_dbg = 0;
  logic [NS-1:0] m_stat = '0;

  task automatic compare(input exp_t e);
    checks++;
    if (dbg_mode !== e.mode || fetch_port !== e.mode || dbg_enter !== e.enter ||
        vec_take !== e.take || vec_idx !== e.idx || status !== e.stat) begin
      errors++;
      $display("FAIL %s: mode=%b fetch=%b enter=%b take=%b idx=%0d stat=%h expected mode=%b fetch=%b enter=%b take=%b idx=%0d stat=%h",
               e.tag, dbg_mode, fetch_port, dbg_enter, vec_take, vec_idx, status,
               e.mode, e.mode, e.enter, e.take, e.idx, e.stat);
    end
  endtask

  // monitor: pops one expected item per cycle, away from the edge
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) compare(q.pop_front());
  end

  task automatic do_reset(input logic a, input logic b, input string tag);
    exp_t e;
    @(negedge clk);
    rst_n = 0; allow_strap = a; boot_strap = b;
    evt = '0; ext_lo = 0; ext_hi = 0; rfi = 0; clr = '0;
    repeat (2) @(posedge clk);
    #2;
    m_allow = a; m_dbg = a & b; m_stat = '0;
    e.mode = m_dbg; e.enter = 0; e.take = 0; e.idx = '0; e.stat = '0; e.tag = tag;
    compare(e);
  endtask

  // driver: applies one cycle of stimulus and pushes the expected result
  task automatic step(input logic [NS-1:0] en_v, input logic [NE-1:0] ev,
                      input logic lo, input logic hi, input logic rf,
                      input logic [NS-1:0] cl, input string tag);
    exp_t e;
    logic [NS-1:0] s;
    int w;
    @(negedge clk);
    rst_n = 1; en = en_v; evt = ev; ext_lo = lo; ext_hi = hi; rfi = rf; clr = cl;
    s = {hi, lo, ev};
    w = -1;
    if (hi) w = NS - 1;
    else if (lo) w = NS - 2;
    else for (int k = 0; k < NE; k++) if (w < 0 && ev[k]) w = k;
    e.enter = 0; e.take = 0; e.idx = '0; e.tag = tag;
    if (m_dbg) begin
      m_stat = (m_stat & ~cl) | s;
      if (rf) m_dbg = 0;
    end else if (w >= 0 && m_allow && en_v[w]) begin
      e.enter = 1; m_dbg = 1; m_stat = '0; m_stat[w] = 1'b1;
    end else begin
      m_stat = m_stat & ~cl;
      if (w >= 0) begin e.take = 1; e.idx = IW'(w); end
    end
    e.mode = m_dbg; e.stat = m_stat;
    q.push_back(e);
  endtask

  localparam logic [NS-1:0] ALL = '1;
  localparam logic [NS-1:0] NONE = '0;

  initial begin
    // R1 / R3: disallowed, boot strap gated off
    do_reset(0, 1, "R3 reset no debug when disallowed");
    step(ALL, 8'h01, 0, 0, 0, NONE, "R1 event vectors though enabled");
    step(ALL, 8'h00, 0, 1, 0, NONE, "R1 urgent request vectors when disallowed");
    allow_strap = 1; boot_strap = 1;
    step(ALL, 8'h80, 0, 0, 0, NONE, "R2 strap change after reset ignored");
    step(NONE, 8'h00, 0, 0, 0, NONE, "R6 idle index zero");
    // R3 / R7 / R8 / R9: boot in debug
    do_reset(1, 1, "R3 R7 boot into debug");
    step(NONE, 8'h04, 0, 0, 1, NONE, "R8 R9 rfi and event same cycle");
    step(NONE, 8'h00, 0, 0, 1, NONE, "R8 rfi outside debug ignored");
    step(NONE, 8'h00, 0, 0, 0, 10'h004, "R10 clear status bit");
    // R4 / R6: priority with vectors
    step(NONE, 8'h06, 0, 0, 0, NONE, "R4 lowest internal wins");
    step(NONE, 8'h01, 1, 0, 0, NONE, "R4 ordinary request over internal");
    step(NONE, 8'h00, 1, 1, 0, NONE, "R4 urgent over ordinary");
    step(10'h020, 8'h21, 0, 0, 0, NONE, "R4 R6 only winner serviced");
    step(10'h020, 8'h20, 0, 0, 0, NONE, "R5 enabled event enters debug");
    step(10'h020, 8'h04, 0, 0, 0, NONE, "R9 event in debug recorded only");
    step(NONE, 8'h00, 0, 0, 0, 10'h020, "R10 clear cause bit");
    step(NONE, 8'h04, 0, 0, 0, 10'h004, "R10 set wins over clear");
    step(NONE, 8'h00, 0, 0, 1, NONE, "R8 rfi leaves debug");
    step(NONE, 8'h00, 0, 0, 0, ALL, "R10 clear all");
    step(10'h200, 8'h01, 0, 1, 0, ALL, "R5 urgent entry load beats clear");
    step(ALL, 8'h00, 0, 1, 0, NONE, "R9 no re-entry in debug");
    step(ALL, 8'h00, 1, 0, 0, NONE, "R9 ordinary request recorded");
    step(NONE, 8'h00, 0, 0, 1, NONE, "R8 exit again");
    step(NONE, 8'h00, 0, 0, 0, NONE, "R7 idle in run mode");
    // R1 again after a fresh disallowed reset
    do_reset(0, 0, "R1 reset disallowed");
    step(ALL, 8'h00, 1, 0, 0, NONE, "R1 ordinary request vectors");
    step(NONE, 8'h00, 0, 0, 0, NONE, "R6 idle after vector");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule